// File: doc/BRIEF.md
# HI/LO Access Hazard Monitor

This block watches the stream of retired instructions of a CPU and flags timing hazards on the two registers that hold multiply and divide results, called HI and LO below. Each beat gives a valid bit, an access class and the instruction address. An instruction-time counter advances by one on every valid beat, whatever its class. For each of the two registers the monitor keeps three history records: the last move-to, the last move-from and the last multiply/divide operation. Each record holds a timestamp and an address.

On every valid beat the monitor checks three rules against these records. A move-to must not come too soon after a move-from of the same register. A multiply/divide operation must not come too soon after a move-from of either register. A move-from must not read a value that a move-to on the peer register has made stale. When a rule is broken, the monitor raises a one-cycle error pulse. The pulse carries a reason code, the address of the offending instruction and the address of the earlier access it conflicts with. The monitor is placed beside the retirement stage during simulation or emulation to catch code that breaks these spacing rules.

Top module: `hilo_hazard_mon`

## Requirements
- R1: After synchronous reset the error outputs are zero. Every history timestamp holds a sentinel far in the past, so that no rule fires before the first real access.
- R2: The instruction time advances by one on each beat with `beat_vld` high, including class 0 (no HI/LO access). A beat with `beat_vld` low changes neither the time nor any history record and raises no error.
- R3: A move-to on register X (class 1 is HI, class 2 is LO) is flagged with reason 1 when X's last move-from time plus 3 is greater than the current time. The earlier address reported is that move-from's address.
- R4: The move-to spacing rule looks only at the move-from history of the same register. A move-to on one register right after a move-from of the other register is not flagged.
- R5: A multiply/divide operation (class 5) is flagged with reason 2 when the last move-from of HI or of LO lies within the same spacing. HI is checked first. When both are too close, the HI move-from address is reported.
- R6: A move-from on register X (class 3 is HI, class 4 is LO) is flagged with reason 3 when two things hold. The peer register's last move-to is newer than X's last operation, and X's last move-from is older than that operation. The earlier address reported is the peer's move-to address.
- R7: Every valid access stamps its own record with the current time and address, whether or not it was flagged. An operation stamps the operation record of both registers.
- R8: A flagged beat presented at a clock edge produces, after that edge, `err_pulse` high for one cycle. The same cycle shows the reason in `err_code`, the beat's address in `err_addr_now` and the conflicting address in `err_addr_prev`. In every other cycle all four outputs are zero.
- R9: Class codes 0, 6 and 7 access neither register. They only advance the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_vld | input | 1 | Retired instruction present on this cycle |
| beat_cls | input | 3 | Access class: 0 none, 1 move-to HI, 2 move-to LO, 3 move-from HI, 4 move-from LO, 5 multiply/divide |
| beat_addr | input | AW | Instruction address of the beat |
| err_pulse | output | 1 | One-cycle violation indication |
| err_code | output | 2 | Reason: 1 move-to near move-from, 2 operation near move-from, 3 move-from corrupted by peer move-to |
| err_addr_now | output | AW | Address of the offending instruction |
| err_addr_prev | output | AW | Address of the earlier conflicting access |

## Verification
Directed sequences place a move-from and a following move-to at distances of 1, 2 and 3 instructions. Together they show where the spacing rule stops firing. A repeat with invalid beats inserted shows that idle cycles do not count as instructions. An operation preceded by move-froms of LO only, and then of both registers, tells apart the two halves of the operation check and their priority. An operation followed by a peer move-to and then a move-from tells a stale read from a fresh one, and a violating operation that still sets up a later corruption shows that records are stamped even when a beat is flagged. A long seeded random stream with dense hazard classes is then compared beat by beat against a bench model of the history records.

// File: rtl/hilo_mon_pkg.sv
package hilo_mon_pkg;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_MT_HI = 3'd1,
        CLS_MT_LO = 3'd2,
        CLS_MF_HI = 3'd3,
        CLS_MF_LO = 3'd4,
        CLS_OP    = 3'd5
    } acc_cls_e;

    typedef enum logic [1:0] {
        RSN_NONE       = 2'd0,
        RSN_MT_NEAR_MF = 2'd1,
        RSN_OP_NEAR_MF = 2'd2,
        RSN_MF_STALE   = 2'd3
    } reason_e;

    localparam int SEL_HI = 0;
    localparam int SEL_LO = 1;
    localparam int MF_SPACING = 3;

    typedef struct packed {
        logic is_mt;
        logic is_mf;
        logic is_op;
        logic sel_lo;
    } acc_dec_t;

    function automatic acc_dec_t decode_cls(input logic [2:0] cls);
        acc_dec_t d;
        d = '0;
        case (cls)
            CLS_MT_HI: d.is_mt = 1'b1;
            CLS_MT_LO: begin d.is_mt = 1'b1; d.sel_lo = 1'b1; end
            CLS_MF_HI: d.is_mf = 1'b1;
            CLS_MF_LO: begin d.is_mf = 1'b1; d.sel_lo = 1'b1; end
            CLS_OP:    d.is_op = 1'b1;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hilo_timebase.sv
module hilo_timebase #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [TW-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst)      now <= '0;
        else if (adv) now <= now + 1'b1;
    end
endmodule

// File: rtl/hilo_reg_history.sv
module hilo_reg_history #(
    parameter int TW = 32,
    parameter int AW = 32,
    localparam int SW = TW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_mt,
    input  logic                 wr_mf,
    input  logic                 wr_op,
    input  logic signed [SW-1:0] stamp,
    input  logic [AW-1:0]        addr,
    output logic signed [SW-1:0] mt_ts,
    output logic [AW-1:0]        mt_addr,
    output logic signed [SW-1:0] mf_ts,
    output logic [AW-1:0]        mf_addr,
    output logic signed [SW-1:0] op_ts,
    output logic [AW-1:0]        op_addr
);
    localparam logic signed [SW-1:0] SENTINEL = {2'b11, {TW{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            mt_ts   <= SENTINEL;
            mf_ts   <= SENTINEL;
            op_ts   <= SENTINEL;
            mt_addr <= '0;
            mf_addr <= '0;
            op_addr <= '0;
        end else begin
            if (wr_mt) begin mt_ts <= stamp; mt_addr <= addr; end
            if (wr_mf) begin mf_ts <= stamp; mf_addr <= addr; end
            if (wr_op) begin op_ts <= stamp; op_addr <= addr; end
        end
    end
endmodule

// File: rtl/hilo_rule_eval.sv
module hilo_rule_eval
    import hilo_mon_pkg::*;
#(
    parameter int TW = 32,
    parameter int AW = 32,
    localparam int SW = TW + 2
) (
    input  acc_dec_t             dec,
    input  logic signed [SW-1:0] stamp,
    input  logic signed [SW-1:0] mt_ts   [2],
    input  logic [AW-1:0]        mt_addr [2],
    input  logic signed [SW-1:0] mf_ts   [2],
    input  logic [AW-1:0]        mf_addr [2],
    input  logic signed [SW-1:0] op_ts   [2],
    output reason_e              code,
    output logic [AW-1:0]        prev_addr
);
    localparam logic signed [SW-1:0] GAP = SW'(MF_SPACING);

    logic own_i;
    logic peer_i;
    logic near_hi;
    logic near_lo;
    logic near_own;

    always_comb begin
        own_i    = dec.sel_lo;
        peer_i   = ~dec.sel_lo;
        near_hi  = (mf_ts[SEL_HI] + GAP) > stamp;
        near_lo  = (mf_ts[SEL_LO] + GAP) > stamp;
        near_own = own_i ? near_lo : near_hi;
        code      = RSN_NONE;
        prev_addr = '0;
        if (dec.is_mt && near_own) begin
            code      = RSN_MT_NEAR_MF;
            prev_addr = mf_addr[own_i];
        end else if (dec.is_op && near_hi) begin
            code      = RSN_OP_NEAR_MF;
            prev_addr = mf_addr[SEL_HI];
        end else if (dec.is_op && near_lo) begin
            code      = RSN_OP_NEAR_MF;
            prev_addr = mf_addr[SEL_LO];
        end else if (dec.is_mf && (mt_ts[peer_i] > op_ts[own_i])
                     && (mf_ts[own_i] < op_ts[own_i])) begin
            code      = RSN_MF_STALE;
            prev_addr = mt_addr[peer_i];
        end
    end
endmodule

// File: rtl/hilo_hazard_mon.sv
module hilo_hazard_mon
    import hilo_mon_pkg::*;
#(
    parameter int TW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_vld,
    input  logic [2:0]    beat_cls,
    input  logic [AW-1:0] beat_addr,
    output logic          err_pulse,
    output logic [1:0]    err_code,
    output logic [AW-1:0] err_addr_now,
    output logic [AW-1:0] err_addr_prev
);
    localparam int SW = TW + 2;

    logic [TW-1:0]        time_now;
    logic signed [SW-1:0] stamp;
    acc_dec_t             dec;
    logic signed [SW-1:0] mt_ts   [2];
    logic [AW-1:0]        mt_addr [2];
    logic signed [SW-1:0] mf_ts   [2];
    logic [AW-1:0]        mf_addr [2];
    logic signed [SW-1:0] op_ts   [2];
    logic [AW-1:0]        op_addr [2];
    reason_e              code;
    logic [AW-1:0]        prev_addr;

    assign dec   = beat_vld ? decode_cls(beat_cls) : '0;
    assign stamp = $signed({2'b00, time_now});

    hilo_timebase #(.TW(TW)) u_time (
        .clk (clk),
        .rst (rst),
        .adv (beat_vld),
        .now (time_now)
    );

    for (genvar g = 0; g < 2; g++) begin : g_reg
        hilo_reg_history #(.TW(TW), .AW(AW)) u_hist (
            .clk     (clk),
            .rst     (rst),
            .wr_mt   (dec.is_mt && (dec.sel_lo == 1'(g))),
            .wr_mf   (dec.is_mf && (dec.sel_lo == 1'(g))),
            .wr_op   (dec.is_op),
            .stamp   (stamp),
            .addr    (beat_addr),
            .mt_ts   (mt_ts[g]),
            .mt_addr (mt_addr[g]),
            .mf_ts   (mf_ts[g]),
            .mf_addr (mf_addr[g]),
            .op_ts   (op_ts[g]),
            .op_addr (op_addr[g])
        );
    end

    hilo_rule_eval #(.TW(TW), .AW(AW)) u_rule (
        .dec       (dec),
        .stamp     (stamp),
        .mt_ts     (mt_ts),
        .mt_addr   (mt_addr),
        .mf_ts     (mf_ts),
        .mf_addr   (mf_addr),
        .op_ts     (op_ts),
        .code      (code),
        .prev_addr (prev_addr)
    );

    always_ff @(posedge clk) begin
        if (rst || code == RSN_NONE) begin
            err_pulse     <= 1'b0;
            err_code      <= '0;
            err_addr_now  <= '0;
            err_addr_prev <= '0;
        end else begin
            err_pulse     <= 1'b1;
            err_code      <= code;
            err_addr_now  <= beat_addr;
            err_addr_prev <= prev_addr;
        end
    end

    // R2: time follows valid beats only
    p_time_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !beat_vld |=> $stable(time_now));
    p_time_step_r2: assert property (@(posedge clk) disable iff (rst)
        beat_vld |=> time_now == $past(time_now) + 1'b1);
    p_err_needs_beat_r2: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(beat_vld));
    // R3, R5, R6: reason matches class of the flagged beat
    p_mt_reason_r3: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_code == 2'd1) |->
        ($past(beat_cls) == CLS_MT_HI || $past(beat_cls) == CLS_MT_LO));
    p_op_reason_r5: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_code == 2'd2) |-> $past(beat_cls) == CLS_OP);
    p_mf_reason_r6: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_code == 2'd3) |->
        ($past(beat_cls) == CLS_MF_HI || $past(beat_cls) == CLS_MF_LO));
    // R8: output framing
    p_code_set_r8: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_code != 2'd0);
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> (err_code == 2'd0 && err_addr_now == '0 && err_addr_prev == '0));
    p_addr_now_r8: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_addr_now == $past(beat_addr));
    // R9: unused classes never flag
    p_idle_cls_r9: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && (beat_cls == 3'd0 || beat_cls > 3'd5)) |=> !err_pulse);

endmodule

// File: tb/tb_hilo_hazard_mon.sv
module tb_hilo_hazard_mon;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          beat_vld;
    logic [2:0]    beat_cls;
    logic [AW-1:0] beat_addr;
    logic          err_pulse;
    logic [1:0]    err_code;
    logic [AW-1:0] err_addr_now;
    logic [AW-1:0] err_addr_prev;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    hilo_hazard_mon #(.TW(32), .AW(AW)) dut (
        .clk(clk), .rst(rst), .beat_vld(beat_vld), .beat_cls(beat_cls),
        .beat_addr(beat_addr), .err_pulse(err_pulse), .err_code(err_code),
        .err_addr_now(err_addr_now), .err_addr_prev(err_addr_prev)
    );

    // bench model of the histories, index 0 = HI, 1 = LO
    longint        m_now;
    longint        m_mt_t [2];
    longint        m_mf_t [2];
    longint        m_op_t [2];
    logic [AW-1:0] m_mt_a [2];
    logic [AW-1:0] m_mf_a [2];

    function automatic void model_reset();
        m_now = 0;
        for (int i = 0; i < 2; i++) begin
            m_mt_t[i] = -64'sd1000000000000; m_mf_t[i] = -64'sd1000000000000;
            m_op_t[i] = -64'sd1000000000000;
            m_mt_a[i] = '0; m_mf_a[i] = '0;
        end
    endfunction

    // returns {code, prev} and advances the model
    function automatic logic [AW+1:0] model_step(input logic vld, input logic [2:0] cls,
                                                 input logic [AW-1:0] a);
        logic [1:0]    c;
        logic [AW-1:0] p;
        int            r;
        c = 2'd0; p = '0;
        if (!vld) return '0;
        r = (cls == 3'd2 || cls == 3'd4) ? 1 : 0;
        if (cls == 3'd1 || cls == 3'd2) begin
            if (m_mf_t[r] + 3 > m_now) begin c = 2'd1; p = m_mf_a[r]; end
            m_mt_t[r] = m_now; m_mt_a[r] = a;
        end else if (cls == 3'd5) begin
            if (m_mf_t[0] + 3 > m_now) begin c = 2'd2; p = m_mf_a[0]; end
            else if (m_mf_t[1] + 3 > m_now) begin c = 2'd2; p = m_mf_a[1]; end
            m_op_t[0] = m_now; m_op_t[1] = m_now;
        end else if (cls == 3'd3 || cls == 3'd4) begin
            if (m_mt_t[1-r] > m_op_t[r] && m_mf_t[r] < m_op_t[r]) begin
                c = 2'd3; p = m_mt_a[1-r];
            end
            m_mf_t[r] = m_now; m_mf_a[r] = a;
        end
        m_now++;
        return {c, p};
    endfunction

    task automatic check_out(input string req, input logic [1:0] ec,
                             input logic [AW-1:0] en, input logic [AW-1:0] ep);
        logic ex_p;
        ex_p = (ec != 2'd0);
        vectors++;
        if (err_pulse !== ex_p || err_code !== ec || err_addr_now !== en
            || err_addr_prev !== ep) begin
            misses++;
            $display("FAIL %s: got pulse=%0b code=%0d now=%h prev=%h, expected pulse=%0b code=%0d now=%h prev=%h",
                     req, err_pulse, err_code, err_addr_now, err_addr_prev,
                     ex_p, ec, en, ep);
        end
    endtask

    // hand: expected code from the requirement, -1 when left to the model only
    task automatic beat(input logic vld, input logic [2:0] cls, input logic [AW-1:0] a,
                        input string req, input int hand);
        logic [AW+1:0] e;
        @(negedge clk);
        beat_vld = vld; beat_cls = cls; beat_addr = a;
        e = model_step(vld, cls, a);
        @(posedge clk);
        #1;
        check_out(req, e[AW+1:AW], (e[AW+1:AW] != 0) ? a : '0, e[AW-1:0]);
        if (hand >= 0) begin
            vectors++;
            if (int'(err_code) != hand) begin
                misses++;
                $display("FAIL %s: got code=%0d expected code=%0d", req, err_code, hand);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; beat_vld = 1'b0; beat_cls = '0; beat_addr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst = 1'b1; beat_vld = 1'b0; beat_cls = '0; beat_addr = '0;
        do_reset();
        #1;
        check_out("R1", 2'd0, '0, '0);
        // R1: first accesses after reset see sentinel history
        beat(1, 3'd1, 32'h10, "R1", 0);
        beat(1, 3'd5, 32'h14, "R1", 0);
        beat(1, 3'd3, 32'h18, "R1", 0);

        // R3: spacing 1, 2 flagged, 3 clean
        do_reset();
        beat(1, 3'd3, 32'h100, "R3", -1);
        beat(1, 3'd1, 32'h104, "R3", 1);
        do_reset();
        beat(1, 3'd4, 32'h200, "R3", -1);
        beat(1, 3'd0, 32'h204, "R9", 0);
        beat(1, 3'd2, 32'h208, "R3", 1);
        beat(1, 3'd0, 32'h20c, "R8", 0);
        do_reset();
        beat(1, 3'd3, 32'h300, "R3", -1);
        beat(1, 3'd6, 32'h304, "R9", 0);
        beat(1, 3'd7, 32'h308, "R9", 0);
        beat(1, 3'd1, 32'h30c, "R3", 0);

        // R2: invalid beats do not advance time
        do_reset();
        beat(1, 3'd3, 32'h400, "R2", -1);
        for (int i = 0; i < 5; i++) beat(0, 3'd1, 32'h404 + i, "R2", 0);
        beat(1, 3'd1, 32'h420, "R2", 1);

        // R4: other register not affected
        do_reset();
        beat(1, 3'd3, 32'h500, "R4", -1);
        beat(1, 3'd2, 32'h504, "R4", 0);

        // R5: LO only, then both (HI priority)
        do_reset();
        beat(1, 3'd4, 32'h600, "R5", -1);
        beat(1, 3'd5, 32'h604, "R5", 2);
        do_reset();
        beat(1, 3'd3, 32'h700, "R5", -1);
        beat(1, 3'd4, 32'h704, "R5", -1);
        beat(1, 3'd5, 32'h708, "R5", 2);

        // R6: stale read, then fresh read
        do_reset();
        beat(1, 3'd5, 32'h800, "R6", 0);
        beat(1, 3'd2, 32'h804, "R6", 0);
        beat(1, 3'd3, 32'h808, "R6", 3);
        beat(1, 3'd0, 32'h80c, "R6", 0);
        beat(1, 3'd0, 32'h810, "R6", 0);
        beat(1, 3'd3, 32'h814, "R6", 0);

        // R7: flagged operation still stamps, later corruption seen
        do_reset();
        beat(1, 3'd3, 32'h900, "R7", -1);
        beat(1, 3'd5, 32'h904, "R7", 2);
        beat(1, 3'd2, 32'h908, "R7", 0);
        beat(1, 3'd3, 32'h90c, "R7", 3);
        // R7: newest move-from is the one reported
        do_reset();
        beat(1, 3'd3, 32'ha00, "R7", -1);
        beat(1, 3'd3, 32'ha04, "R7", -1);
        beat(1, 3'd1, 32'ha08, "R7", 1);

        // random stream against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic v;
            logic [2:0] c;
            v = ($urandom_range(0, 9) < 8);
            c = 3'($urandom_range(0, 7));
            beat(v, c, $urandom, "R8", -1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule